// File: doc/BRIEF.md
# Triggered Conversion Sequencer

This block drives an external analog-to-digital converter through a list of conversion slots held in writable registers. Each slot names the 4-bit input channel to convert. A start trigger launches a burst of back-to-back conversions. The burst length is one more than a programmable count.

Each result lands in the result register whose index matches its slot. The slot pointer does not rewind when a burst finishes. The next trigger therefore continues with the following slots. Two triggers can thus fill two consecutive groups of result registers, for example one group per switching event.

A software reset input puts the pointer back on slot 0 so that the same session can be repeated. The converter itself is external. It is reached through a start/channel/done/data handshake.

Top module: `conv_seq`

## Requirements
- R1: After reset the block is idle with the pointer on slot 0. `adc_start`, `eos` and `trig_err` are low, and every result register reads 0.
- R2: A trigger accepted while idle starts exactly `maxc`+1 conversions, where `maxc` is the count register. A count of 2 gives three conversions.
- R3: Each conversion presents on `adc_chan` the channel written for the current slot. Slots are visited in increasing index order.
- R4: The `adc_data` value returned with `adc_done` is stored in the result register with the same index as the slot. `rd_data` shows result register `rd_addr` combinationally.
- R5: When a burst ends, the pointer rests on the slot after the last one used, and the next trigger begins there. After a burst of three from slot 0, the next burst starts at slot 3.
- R6: The burst length is the count register value held before the edge that accepts the trigger. A count write made during a burst only affects later bursts.
- R7: A high `sw_rst` on a clock edge moves the pointer to slot 0 and leaves the block idle, aborting any burst in progress. It takes priority over a trigger on the same edge.
- R8: A trigger that arrives while a burst runs is ignored. The burst length and the slot order stay as they were, and `trig_err` is high for exactly the next cycle.
- R9: During a burst, the pointer steps from the last slot (15 by default) to slot 0 and the burst continues.
- R10: `eos` is high for exactly one cycle. That cycle directly follows the edge on which the final result of a burst is written, and the result is readable during it.
- R11: `adc_start` is a one-cycle pulse. No new start is issued until `adc_done` has returned for the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_we | input | 1 | Write enable for a slot's channel field |
| slot_addr | input | 4 | Slot index to write |
| slot_chan | input | 4 | Channel number written to the slot |
| maxc_we | input | 1 | Write enable for the count register |
| maxc_val | input | 4 | Count value (conversions per burst minus one) |
| trig | input | 1 | Start trigger, sampled on each edge |
| sw_rst | input | 1 | Pointer reset / abort |
| adc_start | output | 1 | Start pulse to the converter |
| adc_chan | output | 4 | Channel for the current conversion |
| adc_done | input | 1 | Converter completion pulse |
| adc_data | input | 12 | Converter result, valid with adc_done |
| rd_addr | input | 4 | Result register index to read |
| rd_data | output | 12 | Selected result register |
| eos | output | 1 | End-of-burst pulse |
| trig_err | output | 1 | Pulse flagging a trigger that was ignored |

## Verification
The hardest state to reach from the ports is a wrap from slot 15 to slot 0 inside one burst. Reaching it needs an earlier sequence of bursts to leave the pointer partway along the slot list. The stimulus table chains bursts of 3, 3 and 1 conversions, which leaves the pointer at slot 7. A ten-conversion burst then crosses the end of the list.

A late trigger combined with a count write during a running burst is driven from a directed test. That test times both to fall between a start pulse and its completion, and then checks the lengths of that burst and of the following one.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_LAUNCH = 2'd1,
    SEQ_WAIT   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/conv_seq_regs.sv
module conv_seq_regs #(
  parameter int NUM_SLOTS = 16,
  parameter int CH_W      = 4,
  parameter int DATA_W    = 12,
  parameter int PTR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_we,
  input  logic [PTR_W-1:0]  slot_addr,
  input  logic [CH_W-1:0]   slot_chan,
  input  logic [PTR_W-1:0]  cur_slot,
  output logic [CH_W-1:0]   cur_chan,
  input  logic              res_we,
  input  logic [DATA_W-1:0] res_data,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [CH_W-1:0]   chan_q [NUM_SLOTS];
  logic [DATA_W-1:0] res_q  [NUM_SLOTS];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic chan_en, res_en;
    assign chan_en = slot_we && (slot_addr == PTR_W'(i));
    assign res_en  = res_we  && (cur_slot  == PTR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chan_q[i] <= '0;
        res_q[i]  <= '0;
      end else begin
        if (chan_en) chan_q[i] <= slot_chan;
        if (res_en)  res_q[i]  <= res_data;
      end
    end
  end

  assign cur_chan = chan_q[cur_slot];
  assign rd_data  = res_q[rd_addr];
endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
  import conv_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int PTR_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             maxc_we,
  input  logic [PTR_W-1:0] maxc_val,
  input  logic             trig,
  input  logic             sw_rst,
  input  logic             adc_done,
  output logic             adc_start,
  output logic             res_we,
  output logic [PTR_W-1:0] cur_slot,
  output logic             busy,
  output logic             eos,
  output logic             trig_err
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_SLOTS - 1);

  seq_state_t       state_q, state_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [PTR_W-1:0] left_q, left_d;
  logic [PTR_W-1:0] maxc_q, maxc_d;
  logic             eos_q, eos_d;
  logic             err_q, err_d;

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    left_d  = left_q;
    maxc_d  = maxc_we ? maxc_val : maxc_q;
    eos_d   = 1'b0;
    err_d   = 1'b0;
    res_we  = 1'b0;
    if (sw_rst) begin
      state_d = SEQ_IDLE;
      ptr_d   = '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (trig) begin
            state_d = SEQ_LAUNCH;
            left_d  = maxc_q;
          end
        end
        SEQ_LAUNCH: begin
          err_d   = trig;
          state_d = SEQ_WAIT;
        end
        SEQ_WAIT: begin
          err_d = trig;
          if (adc_done) begin
            res_we = 1'b1;
            ptr_d  = (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
            if (left_q == '0) begin
              state_d = SEQ_IDLE;
              eos_d   = 1'b1;
            end else begin
              left_d  = left_q - PTR_W'(1);
              state_d = SEQ_LAUNCH;
            end
          end
        end
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      ptr_q   <= '0;
      left_q  <= '0;
      maxc_q  <= '0;
      eos_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      left_q  <= left_d;
      maxc_q  <= maxc_d;
      eos_q   <= eos_d;
      err_q   <= err_d;
    end
  end

  assign adc_start = (state_q == SEQ_LAUNCH);
  assign busy      = (state_q != SEQ_IDLE);
  assign cur_slot  = ptr_q;
  assign eos       = eos_q;
  assign trig_err  = err_q;
endmodule

// File: rtl/conv_seq.sv
module conv_seq #(
  parameter int NUM_SLOTS = 16,
  parameter int CH_W      = 4,
  parameter int DATA_W    = 12,
  localparam int PTR_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_we,
  input  logic [PTR_W-1:0]  slot_addr,
  input  logic [CH_W-1:0]   slot_chan,
  input  logic              maxc_we,
  input  logic [PTR_W-1:0]  maxc_val,
  input  logic              trig,
  input  logic              sw_rst,
  output logic              adc_start,
  output logic [CH_W-1:0]   adc_chan,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              eos,
  output logic              trig_err
);
  logic             res_we;
  logic             busy;
  logic [PTR_W-1:0] cur_slot;

  conv_seq_ctrl #(.NUM_SLOTS(NUM_SLOTS), .PTR_W(PTR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .maxc_we  (maxc_we),
    .maxc_val (maxc_val),
    .trig     (trig),
    .sw_rst   (sw_rst),
    .adc_done (adc_done),
    .adc_start(adc_start),
    .res_we   (res_we),
    .cur_slot (cur_slot),
    .busy     (busy),
    .eos      (eos),
    .trig_err (trig_err)
  );

  conv_seq_regs #(.NUM_SLOTS(NUM_SLOTS), .CH_W(CH_W), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_we  (slot_we),
    .slot_addr(slot_addr),
    .slot_chan(slot_chan),
    .cur_slot (cur_slot),
    .cur_chan (adc_chan),
    .res_we   (res_we),
    .res_data (adc_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk #(
  parameter int NUM_SLOTS = 16,
  parameter int PTR_W     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig,
  input logic             sw_rst,
  input logic             adc_start,
  input logic             adc_done,
  input logic             eos,
  input logic             trig_err,
  input logic             busy,
  input logic [PTR_W-1:0] cur_slot
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_SLOTS - 1);

  // R11
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> busy);

  // R10
  eos_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eos |=> !eos);

  // R10
  eos_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eos |-> !busy);

  // R8
  trig_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && busy && !sw_rst) |=> trig_err);

  // R7
  sw_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (!busy && cur_slot == '0));

  // R9
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !adc_start && adc_done && !sw_rst && cur_slot == LAST) |=> (cur_slot == '0));
endmodule

bind conv_seq conv_seq_chk #(.NUM_SLOTS(NUM_SLOTS), .PTR_W(PTR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .trig     (trig),
  .sw_rst   (sw_rst),
  .adc_start(adc_start),
  .adc_done (adc_done),
  .eos      (eos),
  .trig_err (trig_err),
  .busy     (busy),
  .cur_slot (cur_slot)
);

// File: tb/conv_seq_bench.sv
`timescale 1ns/100ps
module conv_seq_bench;
  localparam int NS = 16;

  logic        clk, rst_n;
  logic        slot_we, maxc_we, trig, sw_rst, adc_done;
  logic [3:0]  slot_addr, slot_chan, maxc_val, rd_addr, adc_chan;
  logic [11:0] adc_data, rd_data;
  logic        adc_start, eos, trig_err;

  int checks = 0, fails = 0;
  int nconv = 0, viol = 0, cd = 0;
  logic [3:0] pend_ch;
  logic [3:0] chan_log [256];

  // stimulus table: {count, expected first slot}
  localparam logic [7:0] VEC [4] = '{8'h20, 8'h23, 8'h06, 8'h97};

  conv_seq u_conv_seq (
    .clk(clk), .rst_n(rst_n), .slot_we(slot_we), .slot_addr(slot_addr),
    .slot_chan(slot_chan), .maxc_we(maxc_we), .maxc_val(maxc_val),
    .trig(trig), .sw_rst(sw_rst), .adc_start(adc_start), .adc_chan(adc_chan),
    .adc_done(adc_done), .adc_data(adc_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .eos(eos), .trig_err(trig_err)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  function automatic logic [3:0] cfg_ch(int s);
    return 4'((s * 7 + 3) % NS);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model: done two cycles after a start
  initial begin
    adc_done = 1'b0;
    adc_data = '0;
    forever begin
      @(negedge clk);
      if (adc_done) adc_done = 1'b0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          adc_done = 1'b1;
          adc_data = {8'(nconv), pend_ch};
          nconv++;
        end
      end
      if (adc_start) begin
        if (cd != 0 || adc_done) viol++;
        pend_ch = adc_chan;
        chan_log[nconv[7:0]] = adc_chan;
        cd = 2;
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic wr_max(input int v);
    @(negedge clk); maxc_we = 1'b1; maxc_val = 4'(v);
    @(negedge clk); maxc_we = 1'b0;
  endtask

  task automatic fire();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic finish_burst(input int mx, input int start, input int base);
    int wait_n = 0;
    while (!eos && wait_n < 500) begin
      @(negedge clk);
      wait_n++;
    end
    chk(eos == 1'b1, "R10 eos seen", int'(eos), 1);
    chk(nconv - base == mx + 1, "R2 conversions per burst", nconv - base, mx + 1);
    for (int i = 0; i <= mx; i++) begin
      int s = (start + i) % NS;
      chk(chan_log[8'(base + i)] == cfg_ch(s), "R3 channel order",
          int'(chan_log[8'(base + i)]), int'(cfg_ch(s)));
      rd_addr = 4'(s);
      #0.1;
      chk(rd_data == {8'(base + i), cfg_ch(s)}, "R4 result slot",
          int'(rd_data), int'({8'(base + i), cfg_ch(s)}));
    end
    @(negedge clk);
    chk(eos == 1'b0, "R10 eos one cycle", int'(eos), 0);
  endtask

  initial begin
    int base;
    rst_n = 1'b0; slot_we = 0; maxc_we = 0; trig = 0; sw_rst = 0;
    slot_addr = '0; slot_chan = '0; maxc_val = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!adc_start && !eos && !trig_err, "R1 outputs idle",
        int'({adc_start, eos, trig_err}), 0);
    for (int s = 0; s < NS; s++) begin
      rd_addr = 4'(s);
      #0.1;
      chk(rd_data == '0, "R1 result cleared", int'(rd_data), 0);
    end

    for (int s = 0; s < NS; s++) begin
      @(negedge clk); slot_we = 1'b1; slot_addr = 4'(s); slot_chan = cfg_ch(s);
    end
    @(negedge clk); slot_we = 1'b0;

    // table walk: R2, R3, R4, R5 (held pointer), R9 (wrap in last entry)
    for (int v = 0; v < 4; v++) begin
      wr_max(int'(VEC[v][7:4]));
      base = nconv;
      fire();
      finish_burst(int'(VEC[v][7:4]), int'(VEC[v][3:0]), base);
    end

    // R7: pointer back to slot 0
    @(negedge clk); sw_rst = 1'b1;
    @(negedge clk); sw_rst = 1'b0;
    wr_max(3);
    base = nconv;
    fire();
    // R8: late trigger ignored; R6: count write during burst deferred
    @(negedge clk);
    trig = 1'b1; maxc_we = 1'b1; maxc_val = 4'd1;
    @(negedge clk);
    trig = 1'b0; maxc_we = 1'b0;
    chk(trig_err == 1'b1, "R8 trig_err raised", int'(trig_err), 1);
    @(negedge clk);
    chk(trig_err == 1'b0, "R8 trig_err one cycle", int'(trig_err), 0);
    finish_burst(3, 0, base);       // R7 start at slot 0, R8 length kept
    base = nconv;
    fire();
    finish_burst(1, 4, base);       // R6 new count applies, R5 continues at 4

    // R7: reset with simultaneous trigger, trigger loses
    @(negedge clk); sw_rst = 1'b1; trig = 1'b1;
    @(negedge clk); sw_rst = 1'b0; trig = 1'b0;
    repeat (4) @(negedge clk);
    chk(!adc_start && nconv == base + 2, "R7 trigger under reset ignored", nconv - base, 2);
    base = nconv;
    wr_max(0);
    fire();
    finish_burst(0, 0, base);

    chk(viol == 0, "R11 single outstanding start", viol, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule